// File: doc/BRIEF.md
# Vector Load Address Generator

This block sequences a single vector load instruction into a stream of element reads. A start request supplies an access mode, a scalar base address, a byte stride and a vector length. From then on the block issues one memory read request per cycle, in ascending element order, whenever the memory accepts it. No software loop and no per-element stall logic are involved. Each returned word is written into the matching destination element of a vector register, and a one-cycle done pulse closes the instruction.

Three address patterns are produced by one sequencer. Contiguous loads step by the element size, as a cache line fill does. Strided loads step by a byte stride taken from a scalar register. Gather loads add a per-element offset, read from a second vector register through an index read port, to the base. Memory banking is reflected only as a bank number that comes with each request. It is taken from the address bits just above the element byte offset, so a contiguous full-length load visits every bank exactly once.

Top module: `vload_agu`

## Requirements
- R1: Mode 0 (contiguous) requests element i at base + 4*i.
- R2: Mode 1 (strided) requests element i at base + i*stride, with all address arithmetic modulo 2^32 and no fault reporting.
- R3: Mode 2 (gather) requests element i at base + idx_data_i, where idx_addr_o equals i while element i is being requested.
- R4: Requests are issued in ascending element order, at most one accepted per cycle, exactly as many as the effective length; an unaccepted request stays asserted with the same address and index.
- R5: mem_bank_o equals address bits [4:2] of the request (8 banks, 4-byte elements); a contiguous load of length 8 touches all 8 banks once.
- R6: The k-th returned word (mem_rvalid_i) is written to element k, with wr_en_o high in the cycle after the return.
- R7: done_o is a one-cycle pulse in the cycle after the last element write; busy_o is high from the cycle after an accepted start up to, but not including, the done cycle.
- R8: A start while busy_o is high is ignored: it changes no address, no element count and starts no further load.
- R9: A length of 0 is treated as 1 and a length above 8 as 8.
- R10: Mode 3 behaves exactly as mode 0.
- R11: After reset busy_o, done_o, mem_req_o and wr_en_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a load (taken when not busy) |
| mode_i | input | 2 | 0 contiguous, 1 strided, 2 gather, 3 as 0 |
| base_i | input | 32 | Scalar base byte address |
| stride_i | input | 32 | Byte stride for mode 1 |
| vlen_i | input | 4 | Element count, clamped to 1..8 |
| idx_addr_o | output | 3 | Element number read from the index register |
| idx_data_i | input | 32 | Byte offset for that element |
| mem_req_o | output | 1 | Read request valid |
| mem_gnt_i | input | 1 | Memory accepts the request this cycle |
| mem_addr_o | output | 32 | Request byte address |
| mem_bank_o | output | 3 | Bank number of the request |
| mem_rvalid_i | input | 1 | Read data returned, in request order |
| mem_rdata_i | input | 32 | Returned word |
| wr_en_o | output | 1 | Destination element write |
| wr_idx_o | output | 3 | Destination element number |
| wr_data_o | output | 32 | Destination element data |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Random loads mix all four mode codes, random bases and strides (including negative strides and bases near the top of the address space), random gather offsets and lengths from 0 to 9, under a memory that grants and returns with random gaps. Contiguous full-length loads show that every bank appears once, while wrapping strides and negative gather offsets separate correct modulo arithmetic from truncated or saturated sums. Back-pressure gaps distinguish a step taken on acceptance from a step taken on every request cycle, and starts injected mid-load tell an ignored start apart from one that restarts or lengthens the sequence. Lengths 0 and above 8 confirm the clamp.

// File: rtl/vload_pkg.sv
package vload_pkg;
  typedef enum logic [1:0] {
    MODE_UNIT     = 2'd0,
    MODE_STRIDE   = 2'd1,
    MODE_GATHER   = 2'd2,
    MODE_UNIT_ALT = 2'd3
  } vl_mode_e;
endpackage

// File: rtl/vload_seq.sv
module vload_seq #(
  parameter int MAX_VL = 8,
  localparam int CNT_W = $clog2(MAX_VL + 1),
  localparam int IDX_W = $clog2(MAX_VL)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] vlen_i,
  input  logic             gnt_i,
  input  logic             rvalid_i,
  input  logic             wb_last_i,
  output logic             launch_o,
  output logic             busy_o,
  output logic             req_o,
  output logic             accept_o,
  output logic [IDX_W-1:0] iss_idx_o,
  output logic             ret_ok_o,
  output logic [IDX_W-1:0] ret_idx_o,
  output logic             ret_last_o,
  output logic             done_o
);
  logic             busy_q, done_q;
  logic [CNT_W-1:0] vlen_q, vlen_eff;
  logic [CNT_W-1:0] iss_cnt_q, ret_cnt_q;

  always_comb begin
    if (vlen_i == '0)                    vlen_eff = CNT_W'(1);
    else if (vlen_i > CNT_W'(MAX_VL))    vlen_eff = CNT_W'(MAX_VL);
    else                                 vlen_eff = vlen_i;
  end

  assign launch_o   = start_i & ~busy_q;
  assign req_o      = busy_q & (iss_cnt_q < vlen_q);
  assign accept_o   = req_o & gnt_i;
  assign ret_ok_o   = busy_q & rvalid_i & (ret_cnt_q < vlen_q);
  assign ret_last_o = ret_ok_o & (ret_cnt_q == vlen_q - CNT_W'(1));
  assign iss_idx_o  = iss_cnt_q[IDX_W-1:0];
  assign ret_idx_o  = ret_cnt_q[IDX_W-1:0];
  assign busy_o     = busy_q;
  assign done_o     = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      vlen_q    <= '0;
      iss_cnt_q <= '0;
      ret_cnt_q <= '0;
    end else begin
      done_q <= wb_last_i;
      if (launch_o) begin
        busy_q    <= 1'b1;
        vlen_q    <= vlen_eff;
        iss_cnt_q <= '0;
        ret_cnt_q <= '0;
      end else begin
        if (wb_last_i) busy_q    <= 1'b0;
        if (accept_o)  iss_cnt_q <= iss_cnt_q + CNT_W'(1);
        if (ret_ok_o)  ret_cnt_q <= ret_cnt_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/vload_addr_gen.sv
module vload_addr_gen
  import vload_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NUM_BANKS  = 8,
  parameter int ELEM_BYTES = 4,
  localparam int BANK_W    = $clog2(NUM_BANKS),
  localparam int OFF_W     = $clog2(ELEM_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic              advance_i,
  input  logic [ADDR_W-1:0] idx_off_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BANK_W-1:0] bank_o
);
  logic [ADDR_W-1:0] base_q, step_q, acc_q;
  logic              gather_q;
  vl_mode_e          mode;

  assign mode = vl_mode_e'(mode_i);

  // running sum replaces i*stride multiply
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q   <= '0;
      step_q   <= '0;
      acc_q    <= '0;
      gather_q <= 1'b0;
    end else if (launch_i) begin
      base_q   <= base_i;
      acc_q    <= base_i;
      gather_q <= (mode == MODE_GATHER);
      step_q   <= (mode == MODE_STRIDE) ? stride_i : ADDR_W'(ELEM_BYTES);
    end else if (advance_i) begin
      acc_q <= acc_q + step_q;
    end
  end

  assign addr_o = gather_q ? (base_q + idx_off_i) : acc_q;
  assign bank_o = addr_o[OFF_W +: BANK_W];
endmodule

// File: rtl/vload_wb.sv
module vload_wb #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ret_ok_i,
  input  logic              ret_last_i,
  input  logic [IDX_W-1:0]  ret_idx_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              wr_last_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o   <= 1'b0;
      wr_last_o <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o   <= ret_ok_i;
      wr_last_o <= ret_last_i;
      if (ret_ok_i) begin
        wr_idx_o  <= ret_idx_i;
        wr_data_o <= rdata_i;
      end
    end
  end
endmodule

// File: rtl/vload_agu.sv
module vload_agu #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int MAX_VL     = 8,
  parameter int NUM_BANKS  = 8,
  parameter int ELEM_BYTES = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           start_i,
  input  logic [1:0]                     mode_i,
  input  logic [ADDR_W-1:0]              base_i,
  input  logic [ADDR_W-1:0]              stride_i,
  input  logic [$clog2(MAX_VL+1)-1:0]    vlen_i,
  output logic [$clog2(MAX_VL)-1:0]      idx_addr_o,
  input  logic [ADDR_W-1:0]              idx_data_i,
  output logic                           mem_req_o,
  input  logic                           mem_gnt_i,
  output logic [ADDR_W-1:0]              mem_addr_o,
  output logic [$clog2(NUM_BANKS)-1:0]   mem_bank_o,
  input  logic                           mem_rvalid_i,
  input  logic [DATA_W-1:0]              mem_rdata_i,
  output logic                           wr_en_o,
  output logic [$clog2(MAX_VL)-1:0]      wr_idx_o,
  output logic [DATA_W-1:0]              wr_data_o,
  output logic                           busy_o,
  output logic                           done_o
);
  localparam int IDX_W = $clog2(MAX_VL);

  logic             launch, accept, ret_ok, ret_last, wr_last;
  logic [IDX_W-1:0] ret_idx;

  vload_seq #(.MAX_VL(MAX_VL)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .vlen_i     (vlen_i),
    .gnt_i      (mem_gnt_i),
    .rvalid_i   (mem_rvalid_i),
    .wb_last_i  (wr_last),
    .launch_o   (launch),
    .busy_o     (busy_o),
    .req_o      (mem_req_o),
    .accept_o   (accept),
    .iss_idx_o  (idx_addr_o),
    .ret_ok_o   (ret_ok),
    .ret_idx_o  (ret_idx),
    .ret_last_o (ret_last),
    .done_o     (done_o)
  );

  vload_addr_gen #(
    .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .ELEM_BYTES(ELEM_BYTES)
  ) u_agen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .launch_i  (launch),
    .mode_i    (mode_i),
    .base_i    (base_i),
    .stride_i  (stride_i),
    .advance_i (accept),
    .idx_off_i (idx_data_i),
    .addr_o    (mem_addr_o),
    .bank_o    (mem_bank_o)
  );

  vload_wb #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_wb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ret_ok_i   (ret_ok),
    .ret_last_i (ret_last),
    .ret_idx_i  (ret_idx),
    .rdata_i    (mem_rdata_i),
    .wr_en_o    (wr_en_o),
    .wr_idx_o   (wr_idx_o),
    .wr_data_o  (wr_data_o),
    .wr_last_o  (wr_last)
  );
endmodule

// File: rtl/vload_agu_sva.sv
module vload_agu_sva #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_req_o,
  input logic              mem_gnt_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [ADDR_W-1:0] idx_data_i,
  input logic [IDX_W-1:0]  idx_addr_o,
  input logic              wr_en_o,
  input logic              busy_o,
  input logic              done_o
);
  p_req_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);

  p_hold_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(idx_addr_o)));

  p_hold_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> (!$stable(idx_data_i) || $stable(mem_addr_o)));

  p_wr_in_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(busy_o));

  p_done_after_wr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(wr_en_o));

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_busy_ends_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
endmodule

bind vload_agu vload_agu_sva #(.ADDR_W(ADDR_W), .IDX_W($clog2(MAX_VL))) u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_req_o  (mem_req_o),
  .mem_gnt_i  (mem_gnt_i),
  .mem_addr_o (mem_addr_o),
  .idx_data_i (idx_data_i),
  .idx_addr_o (idx_addr_o),
  .wr_en_o    (wr_en_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/tb_vload_agu.sv
`timescale 1ns/1ps
module tb_vload_agu;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic [31:0] base_i = '0, stride_i = '0;
  logic [3:0]  vlen_i = '0;
  logic [2:0]  idx_addr_o;
  logic [31:0] idx_data_i;
  logic        mem_req_o, mem_gnt_i = 1'b0;
  logic [31:0] mem_addr_o;
  logic [2:0]  mem_bank_o;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        wr_en_o;
  logic [2:0]  wr_idx_o;
  logic [31:0] wr_data_o;
  logic        busy_o, done_o;

  always #2.5 clk_i = ~clk_i;

  vload_agu dut (.*);

  logic [31:0] idx_mem [8];
  assign idx_data_i = idx_mem[idx_addr_o];

  int errors = 0, checks = 0, cyc = 0;
  logic [31:0] acc_addr [16];
  logic [2:0]  acc_bank [16];
  logic [31:0] q_addr [16];
  int          q_head = 0, q_tail = 0, acc_n = 0;
  logic [2:0]  wr_idx_log [16];
  logic [31:0] wr_dat_log [16];
  int          wr_cyc [16], rv_cyc [16], wr_n = 0, rv_n = 0;
  int          done_n = 0, done_cyc = 0;
  int          gnt_pct = 70, rv_pct = 60;

  function automatic logic [31:0] mem_val(input logic [31:0] a);
    return {a[15:0], ~a[31:16]} ^ 32'h5a5a_1234;
  endfunction

  function automatic logic [31:0] exp_addr(input logic [1:0] m, input logic [31:0] b,
                                           input logic [31:0] s, input int i,
                                           input logic [31:0] off);
    case (m)
      2'd1:    return b + 32'(i) * s;
      2'd2:    return b + off;
      default: return b + 32'(i) * 32'd4;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // memory model and monitors, all at the falling edge
  always @(negedge clk_i) begin
    cyc++;
    if (rst_ni) begin
      if (wr_en_o && wr_n < 16) begin
        wr_idx_log[wr_n] = wr_idx_o; wr_dat_log[wr_n] = wr_data_o;
        wr_cyc[wr_n] = cyc; wr_n++;
      end
      if (done_o) begin done_n++; done_cyc = cyc; end
      mem_rvalid_i = 1'b0;
      if (q_head != q_tail && ($urandom % 100) < rv_pct) begin
        mem_rvalid_i = 1'b1;
        mem_rdata_i  = mem_val(q_addr[q_head % 16]);
        q_head++;
        if (rv_n < 16) begin rv_cyc[rv_n] = cyc; rv_n++; end
      end
      mem_gnt_i = (($urandom % 100) < gnt_pct);
      if (mem_gnt_i && mem_req_o) begin
        q_addr[q_tail % 16] = mem_addr_o; q_tail++;
        if (acc_n < 16) begin
          acc_addr[acc_n] = mem_addr_o; acc_bank[acc_n] = mem_bank_o;
        end
        acc_n++;
      end
    end
    if (cyc > 150000) begin
      check(1'b0, "watchdog", 32'(cyc), 32'd150000);
      summary();
    end
  end

  task automatic run_load(input logic [1:0] m, input logic [31:0] b, input logic [31:0] s,
                          input logic [3:0] vl, input bit poke, input bit full_banks);
    int ve, waited;
    logic [7:0] seen;
    ve = (vl == 0) ? 1 : ((vl > 8) ? 8 : int'(vl));
    @(negedge clk_i);
    acc_n = 0; wr_n = 0; rv_n = 0; done_n = 0; q_head = 0; q_tail = 0;
    start_i = 1'b1; mode_i = m; base_i = b; stride_i = s; vlen_i = vl;
    @(negedge clk_i);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R7 busy after start", 32'(busy_o), 32'd1);
    if (poke) begin
      @(negedge clk_i);
      start_i = 1'b1; mode_i = m ^ 2'd1; base_i = b ^ 32'hffff_0000;
      stride_i = s + 32'd8; vlen_i = 4'd3;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    waited = 0;
    while (done_n == 0 && waited < 400) begin @(negedge clk_i); waited++; end
    check(done_n == 1, "R7 done seen", 32'(done_n), 32'd1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      check(!mem_req_o && !busy_o, "R8 idle after done (no extra load)",
            {30'd0, mem_req_o, busy_o}, 32'd0);
    end
    check(done_n == 1, "R7 single done pulse", 32'(done_n), 32'd1);
    check(acc_n == ve, "R4/R9 request count", 32'(acc_n), 32'(ve));
    check(wr_n == ve, "R6/R9 write count", 32'(wr_n), 32'(ve));
    seen = '0;
    for (int i = 0; i < ve && i < acc_n; i++) begin
      logic [31:0] ea;
      ea = exp_addr(m, b, s, i, idx_mem[i]);
      check(acc_addr[i] == ea, (m == 2'd1) ? "R2 strided addr" :
            (m == 2'd2) ? "R3 gather addr" : (m == 2'd3) ? "R10 mode3 addr" : "R1 unit addr",
            acc_addr[i], ea);
      check(acc_bank[i] == ea[4:2], "R5 bank field", 32'(acc_bank[i]), 32'(ea[4:2]));
      seen[acc_bank[i]] = 1'b1;
    end
    if (full_banks) check(seen == 8'hff, "R5 all banks once", 32'(seen), 32'hff);
    for (int i = 0; i < ve && i < wr_n; i++) begin
      logic [31:0] ed;
      ed = mem_val(exp_addr(m, b, s, i, idx_mem[i]));
      check(wr_idx_log[i] == 3'(i), "R6 write index order", 32'(wr_idx_log[i]), 32'(i));
      check(wr_dat_log[i] == ed, "R6 write data", wr_dat_log[i], ed);
      if (i < rv_n)
        check(wr_cyc[i] == rv_cyc[i] + 1, "R6 write latency", 32'(wr_cyc[i]),
              32'(rv_cyc[i] + 1));
    end
    if (wr_n > 0)
      check(done_cyc == wr_cyc[wr_n-1] + 1, "R7 done after last write",
            32'(done_cyc), 32'(wr_cyc[wr_n-1] + 1));
  endtask

  initial begin
    void'($urandom(32'd4117));
    for (int i = 0; i < 8; i++) idx_mem[i] = 32'(i) * 32'd4;
    repeat (3) @(negedge clk_i);
    check(!busy_o && !done_o && !mem_req_o && !wr_en_o, "R11 reset state",
          {28'd0, busy_o, done_o, mem_req_o, wr_en_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!busy_o && !mem_req_o, "R11 idle after reset",
          {30'd0, busy_o, mem_req_o}, 32'd0);

    gnt_pct = 100; rv_pct = 100;
    run_load(2'd0, 32'h0000_0100, 32'd0, 4'd8, 1'b0, 1'b1);
    gnt_pct = 50; rv_pct = 50;
    run_load(2'd0, 32'h0000_1010, 32'd0, 4'd8, 1'b0, 1'b1);
    run_load(2'd1, 32'hffff_fff0, 32'h0000_0010, 4'd8, 1'b0, 1'b0);
    run_load(2'd1, 32'h0000_0010, 32'hffff_fffc, 4'd6, 1'b0, 1'b0);
    idx_mem[0] = 32'hffff_fff8; idx_mem[1] = 32'h40; idx_mem[2] = 32'h0;
    idx_mem[3] = 32'h7fff_fffc; idx_mem[4] = 32'h14;
    run_load(2'd2, 32'h0000_0004, 32'd0, 4'd5, 1'b0, 1'b0);
    run_load(2'd3, 32'h0000_2000, 32'd64, 4'd4, 1'b0, 1'b0);
    run_load(2'd0, 32'h0000_3000, 32'd0, 4'd0, 1'b0, 1'b0);
    run_load(2'd1, 32'h0000_3000, 32'd12, 4'd15, 1'b0, 1'b0);
    run_load(2'd1, 32'h0000_4000, 32'd8, 4'd2, 1'b1, 1'b0);
    run_load(2'd2, 32'h0000_5000, 32'd0, 4'd1, 1'b1, 1'b0);

    for (int r = 0; r < 60; r++) begin
      for (int i = 0; i < 8; i++) idx_mem[i] = $urandom;
      gnt_pct = 30 + ($urandom % 71);
      rv_pct  = 30 + ($urandom % 71);
      run_load(2'($urandom % 4), $urandom,
               ($urandom % 2) ? $urandom : 32'(($urandom % 16) * 4),
               4'($urandom % 10), 1'($urandom % 2), 1'b0);
    end
    summary();
  end
endmodule